// File: doc/BRIEF.md
# PLL Holdover and Freerun Controller

This block holds the digital control that moves a clock PLL out of normal tracking and into one of two fallback states. In holdover the phase-frequency detector is held in reset and the charge pump that the current loop uses is tristated, so the loop-filter charge stays frozen. In freerun, which is legal only when the loop filter is external, the high-voltage pump is tristated and a resistor ties the filter node to half the supply. The block does not model the pumps, the filter or the oscillator. It only drives their control pins and reports which state is in effect.

A fallback state can be forced by software through two manual bits of an 8-bit control byte. It can also be entered automatically when the references are lost, and which loss counts depends on whether reference autoswitching is enabled. The inputs are plain, level-sampled control and status signals. The outputs are registered, so every result appears one clock after the inputs that cause it. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `pll_hold_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next cycle shows tracking: all six outputs are 0, so both pumps are active and the bias resistor is disconnected.
- R2: Every output is registered. A change on any input shows on the outputs after the next rising clock edge and not before it.
- R3: Holdover drive: `pfd_rst_o`=1 and `mid_bias_en_o`=0. The pump of the current loop is tristated: `hv_cp_tri_o`=1 when `ext_loop_i`=1 and `lv_cp_tri_o`=1 when `ext_loop_i`=0, and the other pump stays active. Status is `hold_st_o`=1 and `free_st_o`=0.
- R4: Freerun drive: `pfd_rst_o`=1, `hv_cp_tri_o`=1, `lv_cp_tri_o`=0 and `mid_bias_en_o`=1. Status is `free_st_o`=1 and `hold_st_o`=0.
- R5: Control bit 6 (manual hold) gives holdover whatever the other bits are, unless bit 7 also applies.
- R6: Control bit 7 (manual freerun) with `ext_loop_i`=1 gives freerun.
- R7: Control bit 7 with `ext_loop_i`=0 gives the holdover drive of R3. In this case both `hold_st_o` and `free_st_o` read 1.
- R8: With no manual bit set, automatic holdover is entered when bit 1 (autohold) is 1, bit 2 (freerun-versus-holdover select) is 0, and the trigger of R9 is true.
- R9: The trigger depends on bit 0 (autoswitch). When bit 0 is 0, the trigger is `ref_lost_i[ref_act_i]`, the loss flag of the selected reference. When bit 0 is 1, all `ref_lost_i` bits must be 1.
- R10: With no manual bit set, bits 1 and 2 both 1, `ext_loop_i`=1 and the trigger true give freerun. With `ext_loop_i`=0, the same bits give tracking.
- R11: An automatic state is left on the cycle after its trigger clears. A manual state holds for as long as its bit stays set, whatever the reference flags do.
- R12: Manual requests win over automatic ones. Where freerun is legal it wins over holdover. Control bits 3 to 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 8 | Control byte (bit 0 autoswitch, 1 autohold, 2 freerun select, 6 manual hold, 7 manual freerun) |
| ext_loop_i | input | 1 | 1 = external loop filter, which uses the high-voltage pump |
| ref_lost_i | input | NREF (2) | Loss-of-reference flag per reference |
| ref_act_i | input | 1 | Index of the selected reference |
| pfd_rst_o | output | 1 | Holds the phase-frequency detector in reset |
| lv_cp_tri_o | output | 1 | Tristates the low-voltage charge pump |
| hv_cp_tri_o | output | 1 | Tristates the high-voltage charge pump |
| mid_bias_en_o | output | 1 | Connects the filter node to mid-supply through a resistor |
| hold_st_o | output | 1 | Holdover status |
| free_st_o | output | 1 | Freerun status |

## Verification
Each result is due exactly one rising edge after the inputs that cause it, because the mode decision is combinational and feeds a single output register. The bench drives inputs on the falling edge and samples the outputs on the following falling edge, one full register stage later. A separate check samples just after an input change, before the next rising edge, to confirm the old value is still showing. The checker compares the outputs with the control inputs as they stood one cycle earlier.

// File: rtl/phc_pkg.sv
package phc_pkg;

  typedef enum logic [1:0] {
    PHC_TRACK = 2'd0,
    PHC_HOLD  = 2'd1,
    PHC_FREE  = 2'd2
  } phc_mode_e;

  typedef struct packed {
    logic pfd_rst;
    logic lv_tri;
    logic hv_tri;
    logic bias_en;
    logic hold_st;
    logic free_st;
  } phc_drv_t;

endpackage

// File: rtl/phc_trigger.sv
module phc_trigger #(
  parameter int NREF  = 2,
  parameter int SEL_W = 1
) (
  input  logic             autoswitch_i,
  input  logic [NREF-1:0]  lost_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             trig_o
);

  logic sel_lost;
  logic all_lost;

  assign all_lost = &lost_i;

  generate
    if ((1 << SEL_W) == NREF) begin : g_full
      assign sel_lost = lost_i[sel_i];
    end else begin : g_guard
      always_comb begin
        sel_lost = 1'b0;
        for (int k = 0; k < NREF; k++)
          if (sel_i == SEL_W'(k)) sel_lost = lost_i[k];
      end
    end
  endgenerate

  // autoswitch needs every reference gone; otherwise only the active one matters
  assign trig_o = autoswitch_i ? all_lost : sel_lost;

endmodule

// File: rtl/phc_arbiter.sv
module phc_arbiter
  import phc_pkg::*;
(
  input  logic      man_free_i,
  input  logic      man_hold_i,
  input  logic      auto_arm_i,
  input  logic      free_pick_i,
  input  logic      ext_i,
  input  logic      trig_i,
  output phc_mode_e mode_o,
  output logic      free_flag_o
);

  always_comb begin
    mode_o      = PHC_TRACK;
    free_flag_o = 1'b0;
    if (man_free_i) begin
      // internal loop cannot freerun: drive holdover, still report freerun
      mode_o      = ext_i ? PHC_FREE : PHC_HOLD;
      free_flag_o = 1'b1;
    end else if (man_hold_i) begin
      mode_o = PHC_HOLD;
    end else if (auto_arm_i && trig_i) begin
      if (!free_pick_i)  mode_o = PHC_HOLD;
      else if (ext_i)    mode_o = PHC_FREE;
    end
  end

endmodule

// File: rtl/phc_drive.sv
module phc_drive
  import phc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  phc_mode_e mode_i,
  input  logic      ext_i,
  input  logic      free_flag_i,
  output phc_drv_t  drv_o
);

  phc_drv_t nxt;

  always_comb begin
    nxt = '0;
    unique case (mode_i)
      PHC_HOLD: begin
        nxt.pfd_rst = 1'b1;
        nxt.hv_tri  = ext_i;
        nxt.lv_tri  = !ext_i;
        nxt.hold_st = 1'b1;
        nxt.free_st = free_flag_i;
      end
      PHC_FREE: begin
        nxt.pfd_rst = 1'b1;
        nxt.hv_tri  = 1'b1;
        nxt.bias_en = 1'b1;
        nxt.free_st = 1'b1;
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) drv_o <= '0;
    else     drv_o <= nxt;
  end

endmodule

// File: rtl/pll_hold_ctrl.sv
module pll_hold_ctrl
  import phc_pkg::*;
#(
  parameter int CTRL_W    = 8,
  parameter int NREF      = 2,
  parameter int BIT_ASW   = 0,
  parameter int BIT_AHOLD = 1,
  parameter int BIT_FSEL  = 2,
  parameter int BIT_MHOLD = 6,
  parameter int BIT_MFREE = 7,
  localparam int SEL_W    = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ext_loop_i,
  input  logic [NREF-1:0]   ref_lost_i,
  input  logic [SEL_W-1:0]  ref_act_i,
  output logic              pfd_rst_o,
  output logic              lv_cp_tri_o,
  output logic              hv_cp_tri_o,
  output logic              mid_bias_en_o,
  output logic              hold_st_o,
  output logic              free_st_o
);

  logic      trig;
  logic      free_flag;
  phc_mode_e mode;
  phc_drv_t  drv;
  logic      ctrl_unused;

  assign ctrl_unused = ^ctrl_i;

  phc_trigger #(.NREF(NREF), .SEL_W(SEL_W)) u_trig (
    .autoswitch_i (ctrl_i[BIT_ASW]),
    .lost_i       (ref_lost_i),
    .sel_i        (ref_act_i),
    .trig_o       (trig)
  );

  phc_arbiter u_arb (
    .man_free_i  (ctrl_i[BIT_MFREE]),
    .man_hold_i  (ctrl_i[BIT_MHOLD]),
    .auto_arm_i  (ctrl_i[BIT_AHOLD]),
    .free_pick_i (ctrl_i[BIT_FSEL]),
    .ext_i       (ext_loop_i),
    .trig_i      (trig),
    .mode_o      (mode),
    .free_flag_o (free_flag)
  );

  phc_drive u_drv (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode),
    .ext_i       (ext_loop_i),
    .free_flag_i (free_flag),
    .drv_o       (drv)
  );

  assign pfd_rst_o     = drv.pfd_rst;
  assign lv_cp_tri_o   = drv.lv_tri;
  assign hv_cp_tri_o   = drv.hv_tri;
  assign mid_bias_en_o = drv.bias_en;
  assign hold_st_o     = drv.hold_st;
  assign free_st_o     = drv.free_st;

endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
  parameter int CTRL_W    = 8,
  parameter int BIT_AHOLD = 1,
  parameter int BIT_MHOLD = 6,
  parameter int BIT_MFREE = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              ext_loop_i,
  input logic              pfd_rst_o,
  input logic              lv_cp_tri_o,
  input logic              hv_cp_tri_o,
  input logic              mid_bias_en_o,
  input logic              hold_st_o,
  input logic              free_st_o
);

  logic live = 1'b0;
  logic ctrl_unused;
  assign ctrl_unused = ^ctrl_i;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  a_r5_manual_hold: assert property (@(posedge clk) disable iff (rst)
    live && $past(ctrl_i[BIT_MHOLD] && !ctrl_i[BIT_MFREE])
      |-> hold_st_o && !free_st_o && pfd_rst_o && !mid_bias_en_o);

  a_r6_manual_free_ext: assert property (@(posedge clk) disable iff (rst)
    live && $past(ctrl_i[BIT_MFREE] && ext_loop_i)
      |-> free_st_o && !hold_st_o && hv_cp_tri_o && !lv_cp_tri_o && mid_bias_en_o);

  a_r7_manual_free_int: assert property (@(posedge clk) disable iff (rst)
    live && $past(ctrl_i[BIT_MFREE] && !ext_loop_i)
      |-> free_st_o && hold_st_o && lv_cp_tri_o && !hv_cp_tri_o && !mid_bias_en_o);

  a_r8_unarmed_track: assert property (@(posedge clk) disable iff (rst)
    live && $past(!ctrl_i[BIT_MFREE] && !ctrl_i[BIT_MHOLD] && !ctrl_i[BIT_AHOLD])
      |-> !pfd_rst_o && !hold_st_o && !free_st_o && !lv_cp_tri_o && !hv_cp_tri_o);

  a_r3_one_pump: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lv_cp_tri_o, hv_cp_tri_o}) && (pfd_rst_o == (lv_cp_tri_o || hv_cp_tri_o)));

  a_r4_bias_in_free: assert property (@(posedge clk) disable iff (rst)
    mid_bias_en_o |-> free_st_o && hv_cp_tri_o && pfd_rst_o);

endmodule

bind pll_hold_ctrl phc_checker #(
  .CTRL_W(CTRL_W), .BIT_AHOLD(BIT_AHOLD), .BIT_MHOLD(BIT_MHOLD), .BIT_MFREE(BIT_MFREE)
) u_phc_chk (
  .clk           (clk),
  .rst           (rst),
  .ctrl_i        (ctrl_i),
  .ext_loop_i    (ext_loop_i),
  .pfd_rst_o     (pfd_rst_o),
  .lv_cp_tri_o   (lv_cp_tri_o),
  .hv_cp_tri_o   (hv_cp_tri_o),
  .mid_bias_en_o (mid_bias_en_o),
  .hold_st_o     (hold_st_o),
  .free_st_o     (free_st_o)
);

// File: tb/tb_pll_hold_ctrl.sv
`timescale 1ns/1ps
module tb_pll_hold_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic       ext = 1'b0;
  logic [1:0] lost = 2'b00;
  logic       sel = 1'b0;
  logic pfd, lvt, hvt, bias, hst, fst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pll_hold_ctrl dut (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .ext_loop_i(ext),
    .ref_lost_i(lost), .ref_act_i(sel),
    .pfd_rst_o(pfd), .lv_cp_tri_o(lvt), .hv_cp_tri_o(hvt),
    .mid_bias_en_o(bias), .hold_st_o(hst), .free_st_o(fst)
  );

  // expected packing {pfd, lv_tri, hv_tri, bias, hold, free}
  localparam logic [5:0] TRK  = 6'b000000;
  localparam logic [5:0] HEXT = 6'b101010;
  localparam logic [5:0] HINT = 6'b110010;
  localparam logic [5:0] FRN  = 6'b101101;
  localparam logic [5:0] FINT = 6'b110011;

  // {ctrl, ext, lost, sel, expected}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 1'b1, 2'b11, 1'b0, TRK },  // R8 not armed
    {8'h40, 1'b1, 2'b00, 1'b0, HEXT},  // R5 R3 external pump
    {8'h40, 1'b0, 2'b00, 1'b0, HINT},  // R5 R3 internal pump
    {8'h80, 1'b1, 2'b00, 1'b0, FRN },  // R6 R4
    {8'h80, 1'b0, 2'b00, 1'b0, FINT},  // R7
    {8'hC0, 1'b1, 2'b00, 1'b0, FRN },  // R12 freerun over hold
    {8'h02, 1'b1, 2'b01, 1'b0, HEXT},  // R8 R9 selected lost
    {8'h02, 1'b1, 2'b01, 1'b1, TRK },  // R9 other ref lost only
    {8'h02, 1'b0, 2'b10, 1'b1, HINT},  // R9 ref 1 selected
    {8'h03, 1'b1, 2'b01, 1'b0, TRK },  // R9 autoswitch needs both
    {8'h03, 1'b1, 2'b11, 1'b0, HEXT},  // R9 both lost
    {8'h06, 1'b1, 2'b11, 1'b0, FRN },  // R10 auto freerun
    {8'h06, 1'b0, 2'b11, 1'b0, TRK },  // R10 internal gives tracking
    {8'h46, 1'b1, 2'b11, 1'b0, HEXT},  // R12 manual over auto
    {8'h04, 1'b1, 2'b11, 1'b0, TRK },  // R8 select bit alone
    {8'h02, 1'b1, 2'b00, 1'b0, TRK },  // R11 no trigger
    {8'h38, 1'b1, 2'b11, 1'b0, TRK }   // R12 bits 3..5 ignored
  };

  function automatic logic [5:0] outs();
    return {pfd, lvt, hvt, bias, hst, fst};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, outs(), exp);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic e, input logic [1:0] l, input logic s);
    ctrl = c; ext = e; lost = l; sel = s;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step();
    step();
    check("R1 reset state", TRK);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:10], VEC[i][9], VEC[i][8:7], VEC[i][6]);
      step();
      check($sformatf("vector %0d", i), VEC[i][5:0]);
    end

    // R2: no change before the edge, change after it
    apply(8'h00, 1'b1, 2'b00, 1'b0);
    step();
    apply(8'h40, 1'b1, 2'b00, 1'b0);
    #1;
    check("R2 before edge", TRK);
    step();
    check("R2 after edge", HEXT);

    // R11: manual hold persists while reference flags move
    apply(8'h40, 1'b1, 2'b11, 1'b0);
    step();
    check("R11 manual persists lost=11", HEXT);
    apply(8'h40, 1'b1, 2'b00, 1'b1);
    step();
    check("R11 manual persists lost=00", HEXT);

    // R11: automatic hold released on the cycle after the trigger clears
    apply(8'h02, 1'b1, 2'b01, 1'b0);
    step();
    check("R11 auto entry", HEXT);
    apply(8'h02, 1'b1, 2'b00, 1'b0);
    step();
    check("R11 auto release", TRK);

    // R10 auto freerun released too
    apply(8'h07, 1'b1, 2'b11, 1'b1);
    step();
    check("R10 auto freerun autoswitch", FRN);
    apply(8'h07, 1'b1, 2'b10, 1'b1);
    step();
    check("R11 auto freerun release", TRK);

    // R1: reset from freerun
    apply(8'h80, 1'b1, 2'b00, 1'b0);
    step();
    check("R6 before reset", FRN);
    rst = 1'b1;
    step();
    check("R1 reset overrides freerun", TRK);
    rst = 1'b0;
    step();
    check("R6 after reset release", FRN);

    finish_run();
  end

endmodule